// File: doc/BRIEF.md
# Multi-Core Debug Run/Halt/Step Controller

This block is the debug control point for a group of processing cores (sixteen by default). A host reaches it over a small register bus with three registers: a run register, a halt register and a single-step register, each holding one bit per core. For every core the block keeps a run or halt state. From that state it drives a per-core execute-enable and a one-cycle advance pulse that lets a halted core execute exactly one instruction.

Each core reports three things back. A breakpoint pulse halts the core just as a host halt write does. A thread-end cleanup level marks a cleanup sequence that must not be stopped. A retire pulse marks each instruction boundary. A halt request does not stop a core mid-instruction. Execute-enable stays high until the instruction in progress retires. The halt state belongs to the core, not to the thread, so a core that is halted when its thread ends is still halted when its next thread starts.

The bus is a plain single-cycle register port. A write is applied on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr` and the current state. It carries no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `core_debug_ctl`

## Requirements
- R1: After reset every core is running: the run register reads 0x0000FFFF, the halt register reads 0, every `core_exec_en` bit is 1 and every `core_step_adv` bit is 0.
- R2: Register word addresses are 0 for run, 1 for halt and 2 for step. Bit c of each register belongs to core c. The step register and address 3 read 0, and bits 31:16 always read 0. Writes to address 3, writes of 0 bits and writes to bits 31:16 change nothing.
- R3: Writing 1 to bit c of the halt register while core c runs makes its halt bit read 1 from the next cycle on. `core_exec_en[c]` stays 1 until a `core_retire[c]` pulse is sampled and is 0 from the cycle after that edge.
- R4: Writing 1 to bit c of the run register while core c is halted, stepping or draining makes it running from the next cycle, with `core_exec_en[c]` at 1.
- R5: In every cycle, the run register read equals the bitwise inverse of the halt register read in bits 15:0.
- R6: A `core_bkpt[c]` pulse on a running core has the same effect as a host halt write to bit c.
- R7: When a halt request for core c (host write or breakpoint) and a run write to bit c land in the same cycle, the halt wins.
- R8: Writing 1 to bit c of the step register while core c is fully halted raises `core_step_adv[c]` for exactly the next cycle, and the halt bit keeps reading 1. Further step writes to core c are ignored until `core_retire[c]` is sampled, after which the core is halted and a new step is accepted.
- R9: A step write to a core that is running, or still draining toward halt, produces no advance pulse and no change of state.
- R10: While `core_thr_end[c]` is high, host halt writes and breakpoints for core c are ignored, and `core_exec_en[c]` is 1 whatever the state.
- R11: A core that is halted when `core_thr_end[c]` rises is still halted after it falls: its halt bit reads 1 and `core_exec_en[c]` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, applied at the clock edge |
| bus_addr | input | 2 | Register word address (0 run, 1 halt, 2 step) |
| bus_wdata | input | 32 | Write data, one bit per core in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_bkpt | input | 16 | Per-core breakpoint-instruction pulse |
| core_thr_end | input | 16 | Per-core thread-end cleanup in progress (level) |
| core_retire | input | 16 | Per-core instruction-retired pulse |
| core_exec_en | output | 16 | Per-core execute enable |
| core_step_adv | output | 16 | Per-core one-instruction advance pulse |

## Verification
Each register write, breakpoint or retire applies at the clock edge where it is sampled. Halt and run read-back and `core_exec_en` therefore change in the cycle right after that edge. `core_step_adv` is registered on the same edge, so it is high for exactly that one following cycle. The only same-cycle effect is `core_thr_end`, which forces execute-enable straight away. The bench drives stimulus late in a cycle and clears it one time unit after the edge. It then reads run and halt back and samples both core outputs before the next edge, comparing each against a per-core state model that it advances once per edge.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  timeunit 1ns;
  timeprecision 1ns;

  // Per-core debug state; halt read-back is 1 in every state but RUN.
  typedef enum logic [1:0] {
    CS_RUN   = 2'd0,  // executing freely
    CS_DRAIN = 2'd1,  // halt requested, waiting for instruction boundary
    CS_HALT  = 2'd2,  // stopped at a boundary
    CS_STEP  = 2'd3   // one instruction granted, waiting for retire
  } core_st_e;

  // Register word indices on the host bus.
  localparam int unsigned REG_RUN  = 0;
  localparam int unsigned REG_HALT = 1;
  localparam int unsigned REG_STEP = 2;
endpackage

// File: rtl/dbg_regif.sv
module dbg_regif #(
  parameter int NUM_CORES = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_CORES-1:0] halted,
  output logic [NUM_CORES-1:0] run_wr,
  output logic [NUM_CORES-1:0] halt_wr,
  output logic [NUM_CORES-1:0] step_wr,
  output logic [DATA_W-1:0]    bus_rdata
);
  timeunit 1ns;
  timeprecision 1ns;
  import dbg_pkg::*;

  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(REG_RUN);
  localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(REG_HALT);
  localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(REG_STEP);

  logic [NUM_CORES-1:0] wbits;

  // Only the implemented per-core bits are looked at; upper bits are dropped.
  assign wbits = bus_we ? bus_wdata[NUM_CORES-1:0] : '0;

  always_comb begin
    run_wr  = '0;
    halt_wr = '0;
    step_wr = '0;
    unique case (bus_addr)
      A_RUN:   run_wr  = wbits;
      A_HALT:  halt_wr = wbits;
      A_STEP:  step_wr = wbits;
      default: ;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_RUN:   bus_rdata[NUM_CORES-1:0] = ~halted;
      A_HALT:  bus_rdata[NUM_CORES-1:0] = halted;
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_core_seq.sv
module dbg_core_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic halt_req,
  input  logic step_req,
  input  logic retire,
  input  logic cleanup,
  output logic halted,
  output logic exec_en,
  output logic step_adv
);
  timeunit 1ns;
  timeprecision 1ns;
  import dbg_pkg::*;

  core_st_e st_q, st_d;
  logic     adv_q, adv_d;
  logic     halt_eff, run_eff;

  // Cleanup masks halt sources; a live halt masks a same-cycle run.
  assign halt_eff = halt_req & ~cleanup;
  assign run_eff  = run_req & ~halt_eff;

  always_comb begin
    st_d  = st_q;
    adv_d = 1'b0;
    unique case (st_q)
      CS_RUN:   if (halt_eff) st_d = CS_DRAIN;
      CS_DRAIN: begin
        if (run_eff)     st_d = CS_RUN;
        else if (retire) st_d = CS_HALT;
      end
      CS_HALT: begin
        if (run_eff) st_d = CS_RUN;
        else if (step_req) begin
          st_d  = CS_STEP;
          adv_d = 1'b1;
        end
      end
      CS_STEP: begin
        if (run_eff)     st_d = CS_RUN;
        else if (retire) st_d = CS_HALT;
      end
      default: st_d = CS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CS_RUN;
      adv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      adv_q <= adv_d;
    end
  end

  assign halted   = (st_q != CS_RUN);
  assign exec_en  = (st_q == CS_RUN) || (st_q == CS_DRAIN) || cleanup;
  assign step_adv = adv_q;
endmodule

// File: rtl/core_debug_ctl.sv
module core_debug_ctl #(
  parameter int NUM_CORES = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_CORES-1:0] core_bkpt,
  input  logic [NUM_CORES-1:0] core_thr_end,
  input  logic [NUM_CORES-1:0] core_retire,
  output logic [NUM_CORES-1:0] core_exec_en,
  output logic [NUM_CORES-1:0] core_step_adv
);
  timeunit 1ns;
  timeprecision 1ns;

  logic [NUM_CORES-1:0] run_wr, halt_wr, step_wr;
  logic [NUM_CORES-1:0] halted_vec;
  logic [NUM_CORES-1:0] halt_any;

  // A breakpoint is routed exactly like a host halt write.
  assign halt_any = halt_wr | core_bkpt;

  dbg_regif #(
    .NUM_CORES(NUM_CORES),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regif (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .halted   (halted_vec),
    .run_wr   (run_wr),
    .halt_wr  (halt_wr),
    .step_wr  (step_wr),
    .bus_rdata(bus_rdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    dbg_core_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_req (run_wr[c]),
      .halt_req(halt_any[c]),
      .step_req(step_wr[c]),
      .retire  (core_retire[c]),
      .cleanup (core_thr_end[c]),
      .halted  (halted_vec[c]),
      .exec_en (core_exec_en[c]),
      .step_adv(core_step_adv[c])
    );
  end
endmodule

// File: rtl/dbg_ctl_checker.sv
module dbg_ctl_checker #(
  parameter int NUM_CORES = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_CORES-1:0] bkpt,
  input logic [NUM_CORES-1:0] thr_end,
  input logic [NUM_CORES-1:0] retire,
  input logic [NUM_CORES-1:0] exec_en,
  input logic [NUM_CORES-1:0] step_adv,
  input logic [NUM_CORES-1:0] halted
);
  timeunit 1ns;
  timeprecision 1ns;

  // R2: upper read bits are always zero.
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_CORES] == '0);

  // R3: a granted host halt shows as halted on the next cycle.
  p_halt_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(1)) |=>
      ((($past(bus_wdata[NUM_CORES-1:0]) & ~$past(thr_end)) & ~halted) == '0));

  // R3: execute-enable only falls after a retire or the end of cleanup.
  p_exec_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(exec_en) & ~exec_en) & ~$past(retire) & ~$past(thr_end)) == '0));

  // R6: a breakpoint outside cleanup halts its core.
  p_bkpt_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bkpt & ~thr_end)) |=> ((($past(bkpt) & ~$past(thr_end)) & ~halted) == '0));

  // R8: the advance pulse lasts one cycle and only goes to halted cores.
  p_adv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_adv & $past(step_adv)) == '0));
  p_adv_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_adv & ~halted) == '0));

  // R10: cleanup keeps every affected core executing.
  p_cleanup_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_end & ~exec_en) == '0));
endmodule

bind core_debug_ctl dbg_ctl_checker #(
  .NUM_CORES(NUM_CORES),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_dbg_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bkpt     (core_bkpt),
  .thr_end  (core_thr_end),
  .retire   (core_retire),
  .exec_en  (core_exec_en),
  .step_adv (core_step_adv),
  .halted   (halted_vec)
);

// File: tb/test_core_debug_ctl.sv
module test_core_debug_ctl;
  timeunit 1ns;
  timeprecision 1ns;

  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] core_bkpt = '0;
  logic [NC-1:0] core_thr_end = '0;
  logic [NC-1:0] core_retire = '0;
  logic [NC-1:0] core_exec_en;
  logic [NC-1:0] core_step_adv;

  // 250 MHz
  always #2 clk = ~clk;

  core_debug_ctl i_core_debug_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .core_bkpt    (core_bkpt),
    .core_thr_end (core_thr_end),
    .core_retire  (core_retire),
    .core_exec_en (core_exec_en),
    .core_step_adv(core_step_adv)
  );

  // Model states: 0 run, 1 draining, 2 halted, 3 stepping.
  int            st_m [NC];
  logic [NC-1:0] adv_m;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] halt_exp();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = (st_m[c] != 0);
    return v;
  endfunction

  function automatic logic [NC-1:0] exec_exp();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = (st_m[c] <= 1) || core_thr_end[c];
    return v;
  endfunction

  // Advance the model by one edge from the currently driven inputs.
  task automatic model_step();
    for (int c = 0; c < NC; c++) begin
      bit h, r, s;
      h = ((bus_we && bus_addr == 2'd1 && bus_wdata[c]) || core_bkpt[c]) && !core_thr_end[c];
      r = bus_we && bus_addr == 2'd0 && bus_wdata[c] && !h;
      s = bus_we && bus_addr == 2'd2 && bus_wdata[c];
      adv_m[c] = 1'b0;
      case (st_m[c])
        0: if (h) st_m[c] = 1;
        1: if (r) st_m[c] = 0; else if (core_retire[c]) st_m[c] = 2;
        2: if (r) st_m[c] = 0; else if (s) begin st_m[c] = 3; adv_m[c] = 1'b1; end
        default: if (r) st_m[c] = 0; else if (core_retire[c]) st_m[c] = 2;
      endcase
    end
  endtask

  // One clock: drive, edge, clear, then read back and compare.
  task automatic cyc(input string tag, input logic we, input logic [1:0] a,
                     input logic [31:0] d, input logic [NC-1:0] bk, input logic [NC-1:0] rt);
    bus_we = we; bus_addr = a; bus_wdata = d; core_bkpt = bk; core_retire = rt;
    model_step();
    @(posedge clk);
    #1;
    bus_we = 1'b0; core_bkpt = '0; core_retire = '0; bus_addr = 2'd0;
    #1;
    chk({tag, " R5 run read"}, bus_rdata, {16'h0, ~halt_exp()});
    bus_addr = 2'd1;
    #1;
    chk({tag, " halt read"}, bus_rdata, {16'h0, halt_exp()});
    chk({tag, " exec_en"}, {16'h0, core_exec_en}, {16'h0, exec_exp()});
    chk({tag, " step_adv"}, {16'h0, core_step_adv}, {16'h0, adv_m});
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 2'd0, '0, '0, '0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) st_m[c] = 0;
    adv_m = '0;
    // R1: values held during reset and just after release.
    #5;
    bus_addr = 2'd0; #1;
    chk("R1 run read in reset", bus_rdata, 32'h0000_FFFF);
    bus_addr = 2'd1; #1;
    chk("R1 halt read in reset", bus_rdata, 32'h0);
    chk("R1 exec_en in reset", {16'h0, core_exec_en}, 32'h0000_FFFF);
    chk("R1 step_adv in reset", {16'h0, core_step_adv}, 32'h0);
    @(posedge clk); #3;
    rst_n = 1'b1;
    idle("R1");

    // R2: address 2 and 3 read zero; ignored writes.
    bus_addr = 2'd2; #0;
    @(posedge clk); #1;
    chk("R2 step reg reads zero", bus_rdata, 32'h0);
    bus_addr = 2'd3; #1;
    chk("R2 addr3 reads zero", bus_rdata, 32'h0);
    #1;
    cyc("R2 reserved halt bits", 1'b1, 2'd1, 32'hFFFF_0000, '0, '0);
    cyc("R2 addr3 write", 1'b1, 2'd3, 32'hFFFF_FFFF, '0, '0);
    cyc("R2 zero halt write", 1'b1, 2'd1, 32'h0, '0, '0);

    // Per-core sweep of the full sequence.
    for (int c = 0; c < NC; c++) begin
      logic [NC-1:0] b;
      b = NC'(1) << c;
      cyc("R3 halt write", 1'b1, 2'd1, 32'(b), '0, '0);
      cyc("R9 step while draining", 1'b1, 2'd2, 32'(b), '0, '0);
      cyc("R3 retire drains", 1'b0, 2'd0, '0, '0, b);
      cyc("R8 step grant", 1'b1, 2'd2, 32'(b), '0, '0);
      cyc("R8 step refused before retire", 1'b1, 2'd2, 32'(b), '0, '0);
      cyc("R8 step retire", 1'b0, 2'd0, '0, '0, b);
      cyc("R8 second step", 1'b1, 2'd2, 32'(b), '0, '0);
      cyc("R8 second retire", 1'b0, 2'd0, '0, '0, b);
      cyc("R2 zero run write", 1'b1, 2'd0, 32'h0, '0, '0);
      cyc("R4 resume", 1'b1, 2'd0, 32'(b), '0, '0);
      cyc("R9 step while running", 1'b1, 2'd2, 32'(b), '0, '0);
      cyc("R6 breakpoint", 1'b0, 2'd0, '0, b, '0);
      cyc("R6 breakpoint retire", 1'b0, 2'd0, '0, '0, b);
      cyc("R4 resume after bkpt", 1'b1, 2'd0, 32'(b), '0, '0);
      cyc("R7 bkpt beats run", 1'b1, 2'd0, 32'(b), b, '0);
      cyc("R7 retire", 1'b0, 2'd0, '0, '0, b);
      cyc("R4 resume", 1'b1, 2'd0, 32'(b), '0, '0);
    end

    // R10/R11: cleanup on a halted core and on a running one.
    cyc("R3 halt core3", 1'b1, 2'd1, 32'h0000_0008, '0, '0);
    cyc("R3 retire core3", 1'b0, 2'd0, '0, '0, 16'h0008);
    core_thr_end = 16'h0028;
    cyc("R10 halt ignored in cleanup", 1'b1, 2'd1, 32'h0000_0020, '0, '0);
    cyc("R10 bkpt ignored in cleanup", 1'b0, 2'd0, '0, 16'h0020, '0);
    idle("R10 cleanup hold");
    core_thr_end = '0;
    idle("R11 halt persists");
    idle("R11 halt persists 2");
    cyc("R4 resume core3", 1'b1, 2'd0, 32'h0000_0008, '0, '0);

    // All cores together.
    cyc("R3 halt all", 1'b1, 2'd1, 32'h0000_FFFF, '0, '0);
    cyc("R3 retire all", 1'b0, 2'd0, '0, '0, 16'hFFFF);
    cyc("R8 step all", 1'b1, 2'd2, 32'h0000_FFFF, '0, '0);
    cyc("R8 retire all", 1'b0, 2'd0, '0, '0, 16'hFFFF);
    cyc("R4 run all", 1'b1, 2'd0, 32'h0000_FFFF, '0, '0);

    // Mixed random traffic against the model.
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r0, r1, r2;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      if (r0[7:4] == 4'd0) core_thr_end = r2[31:16] & r1[31:16] & 16'h5A5A;
      cyc("R7 random mix", r0[0] | r0[1], r0[3:2], r1, r2[15:0] & r1[15:0] & r0[31:16], r2[31:16] | r0[15:0]);
    end
    core_thr_end = '0;
    idle("R11 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule